// File: doc/BRIEF.md
# Packed Fixed-Attribute Assembler

This block takes a stream of 32-bit register writes and builds constant vertex attributes from them. Each attribute has four components (x, y, z, w) in a 24-bit float format. The block treats the components as raw 24-bit fields and does no float arithmetic.

The write port decodes four addresses:

- One address is the slot-select register.
- Three addresses are aliases of a single data register.

Three data words together carry 96 bits. The components are packed across word boundaries, and the words are in reversed order.

When the third word arrives, the block unpacks the four components. In that same clock edge it writes them to the selected entry of a 12-entry attribute store. It then moves on to the next slot, so consecutive attributes can be streamed after a single slot select.

A collection state machine counts the words. Its states are:

- `CS_EMPTY`: no words held.
- `CS_ONE`: one word held.
- `CS_TWO`: two words held.

Its transitions are:

- An accepted data word moves `CS_EMPTY` to `CS_ONE`, and `CS_ONE` to `CS_TWO`.
- In `CS_TWO`, an accepted data word is the commit. It writes the store, increments the slot and returns to `CS_EMPTY`.
- A slot-select write returns any state to `CS_EMPTY`.
- A rejected data word leaves the state where it is.

A combinational read port exposes any store entry so that the store can be checked.

Top module: `attr_pack_assembler`

## Requirements
- R1: After reset, every store entry reads zero, `cur_slot` is 0, `word_count` is 0, and both error outputs are 0.
- R2: A write to address 0 loads `cur_slot` with `wr_data[3:0]`. The upper bits are ignored. The write also clears `word_count` to 0, discarding any partially collected words. The new values are visible after the clock edge of the write.
- R3: `err_immediate` is 1 exactly while `cur_slot` equals 15, the unsupported immediate-submission code.
- R4: A data write while `cur_slot` is 12 or greater is rejected. `err_range` pulses to 1 for the one cycle after that write. `word_count`, `cur_slot` and the store are left unchanged.
- R5: Data addresses 1, 2 and 3 are interchangeable. Words from any mix of them are collected in arrival order, and `word_count` steps 0, 1, 2.
- R6: With accepted words w0, w1, w2 in arrival order, the four components are unpacked as follows:
  - x = w2[23:0]
  - y = {w1[15:0], w2[31:24]}
  - z = {w0[7:0], w1[31:16]}
  - w = w0[31:8]

  `rd_attr` presents them as {w, z, y, x}, with x in bits 23:0, y in bits 47:24, z in bits 71:48 and w in bits 95:72.
- R7: On the third accepted word, the store entry at `cur_slot` is written, `cur_slot` increments by one, and `word_count` returns to 0. All three changes take effect at the clock edge of that word.
- R8: Data words written on consecutive cycles across attribute boundaries are all accepted with no stall, and each completed attribute lands in its own slot.
- R9: `rd_attr` shows the entry selected by `rd_slot` combinationally. When `rd_slot` is 12 or greater it shows zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = slot select, 1..3 = aliased data register |
| wr_data | input | 32 | Write data |
| rd_slot | input | 4 | Store entry to read |
| rd_attr | output | 96 | Selected entry {w,z,y,x} |
| cur_slot | output | 4 | Current target slot |
| word_count | output | 2 | Data words collected for the current attribute |
| err_immediate | output | 1 | Slot is the immediate-submission code 15 |
| err_range | output | 1 | One-cycle pulse after a rejected data write |

## Verification
Two functions can fall in the same clock edge. The first is the commit of a finished attribute, which writes the store and advances the slot. The second is the start of the next attribute, where the following data word is accepted in the very next cycle. The stimulus table provokes this by driving data words on every cycle with no idle gaps, including a run that carries slot 11 into the out-of-range slot 12. Each affected store entry is then read back and compared with values computed from the unpacking rule. The bench also checks that the first word after a commit counts as word one of a fresh attribute rather than being lost or merged into the previous one.

// File: rtl/attr_pkg.sv
`timescale 1ns/1ps
package attr_pkg;
    localparam int WORD_W    = 32;
    localparam int COMP_W    = 24;
    localparam int NUM_SLOTS = 12;
    localparam int SLOT_W    = 4;
    localparam int ADDR_W    = 2;
    localparam int ATTR_W    = 4 * COMP_W;
    localparam logic [SLOT_W-1:0] IMM_CODE = 4'hF;
    localparam logic [ADDR_W-1:0] ADDR_SEL = 2'd0;

    typedef enum logic [1:0] {
        CS_EMPTY = 2'd0,
        CS_ONE   = 2'd1,
        CS_TWO   = 2'd2
    } coll_state_t;

    typedef struct packed {
        logic [COMP_W-1:0] w;
        logic [COMP_W-1:0] z;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] x;
    } attr_vec_t;
endpackage

// File: rtl/attr_unpack.sv
`timescale 1ns/1ps
module attr_unpack
    import attr_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output attr_vec_t         vec
);
    // Components straddle word boundaries; the last word holds x.
    always_comb begin
        vec.x = word2[23:0];
        vec.y = {word1[15:0], word2[31:24]};
        vec.z = {word0[7:0],  word1[31:16]};
        vec.w = word0[31:8];
    end
endmodule

// File: rtl/attr_collector.sv
`timescale 1ns/1ps
module attr_collector
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] held0,
    output logic [WORD_W-1:0] held1,
    output logic              commit,
    output logic [SLOT_W-1:0] slot,
    output logic [1:0]        word_count,
    output logic              err_immediate,
    output logic              err_range
);
    coll_state_t state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [WORD_W-1:0] held0_q, held1_q;
    logic err_q;
    logic sel_wr, data_wr, slot_ok, accept, reject;

    always_comb begin
        sel_wr  = wr_valid && (wr_addr == ADDR_SEL);
        data_wr = wr_valid && (wr_addr != ADDR_SEL);
        slot_ok = (slot_q < SLOT_W'(NUM_SLOTS));
        accept  = data_wr && slot_ok;
        reject  = data_wr && !slot_ok;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        if (sel_wr) begin
            state_d = CS_EMPTY;
            slot_d  = wr_data[SLOT_W-1:0];
        end else if (accept) begin
            unique case (state_q)
                CS_EMPTY: state_d = CS_ONE;
                CS_ONE:   state_d = CS_TWO;
                CS_TWO: begin
                    state_d = CS_EMPTY;
                    slot_d  = slot_q + 1'b1;
                end
                default:  state_d = CS_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_EMPTY;
            slot_q  <= '0;
            held0_q <= '0;
            held1_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            err_q   <= reject;
            if (accept && state_q == CS_EMPTY) held0_q <= wr_data;
            if (accept && state_q == CS_ONE)   held1_q <= wr_data;
        end
    end

    // Outputs
    always_comb begin
        held0         = held0_q;
        held1         = held1_q;
        commit        = accept && (state_q == CS_TWO);
        slot          = slot_q;
        word_count    = state_q;
        err_immediate = (slot_q == IMM_CODE);
        err_range     = err_q;
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (slot == $past(wr_data[SLOT_W-1:0])) && (word_count == 2'd0)); // R2

    AST_IMM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && wr_data[SLOT_W-1:0] == IMM_CODE) |=> err_immediate); // R3

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> err_range && (slot == $past(slot)) && (word_count == $past(word_count))); // R4

    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (slot == $past(slot) + 1'b1) && (word_count == 2'd0)); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && word_count != 2'd2) |=> (word_count == $past(word_count) + 1'b1)); // R5
endmodule

// File: rtl/attr_store.sv
`timescale 1ns/1ps
module attr_store
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  attr_vec_t         wdata,
    input  logic [SLOT_W-1:0] raddr,
    output attr_vec_t         rdata
);
    attr_vec_t mem [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] we_vec;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_entry
        assign we_vec[i] = we && (waddr == SLOT_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n)         mem[i] <= '0;
            else if (we_vec[i]) mem[i] <= wdata;
        end

        AST_ENTRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            we_vec[i] |=> (mem[i] == $past(wdata))); // R7
    end

    always_comb begin
        if (raddr < SLOT_W'(NUM_SLOTS)) rdata = mem[raddr];
        else                            rdata = '0;
    end

    AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec)); // R8
endmodule

// File: rtl/attr_pack_assembler.sv
`timescale 1ns/1ps
module attr_pack_assembler
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ATTR_W-1:0] rd_attr,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [1:0]        word_count,
    output logic              err_immediate,
    output logic              err_range
);
    logic [WORD_W-1:0] held0, held1;
    logic commit;
    attr_vec_t packed_vec, read_vec;

    attr_collector u_coll (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .held0(held0), .held1(held1), .commit(commit),
        .slot(cur_slot), .word_count(word_count),
        .err_immediate(err_immediate), .err_range(err_range)
    );

    attr_unpack u_unpack (
        .word0(held0), .word1(held1), .word2(wr_data), .vec(packed_vec)
    );

    attr_store u_store (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(cur_slot),
        .wdata(packed_vec), .raddr(rd_slot), .rdata(read_vec)
    );

    assign rd_attr = read_vec;

    AST_NO_STORE_AT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot >= SLOT_W'(NUM_SLOTS)) |-> !commit); // R4
endmodule

// File: tb/sim_attr_pack_assembler.sv
`timescale 1ns/1ps
module sim_attr_pack_assembler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_slot = '0;
    logic [95:0] rd_attr;
    logic [3:0]  cur_slot;
    logic [1:0]  word_count;
    logic        err_immediate, err_range;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    attr_pack_assembler u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_slot(rd_slot), .rd_attr(rd_attr),
        .cur_slot(cur_slot), .word_count(word_count),
        .err_immediate(err_immediate), .err_range(err_range)
    );

    typedef struct packed {
        logic [1:0]  addr;
        logic [31:0] data;
        logic [3:0]  slot;
        logic [1:0]  cnt;
        logic        imm;
        logic        rerr;
    } vec_t;

    localparam logic [31:0] WA = 32'h11223344, WB = 32'h55667788, WC = 32'h99AABBCC;
    localparam logic [31:0] WD = 32'hDEADBEEF, WE = 32'h0BADF00D, WF = 32'hCAFE1234;
    localparam logic [31:0] WG = 32'h01020304, WH = 32'hA5A55A5A, WI = 32'h7F00FF80;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 32'h0000_0003, 4'd3,  2'd0, 1'b0, 1'b0},  // R2 select slot 3
        '{2'd1, WA,            4'd3,  2'd1, 1'b0, 1'b0},  // R5
        '{2'd2, WB,            4'd3,  2'd2, 1'b0, 1'b0},  // R5
        '{2'd3, WC,            4'd4,  2'd0, 1'b0, 1'b0},  // R7 commit slot 3
        '{2'd0, 32'hFFFF_FFF5, 4'd5,  2'd0, 1'b0, 1'b0},  // R2 upper bits ignored
        '{2'd3, WD,            4'd5,  2'd1, 1'b0, 1'b0},
        '{2'd0, 32'h0000_0005, 4'd5,  2'd0, 1'b0, 1'b0},  // R2 partial discarded
        '{2'd2, WD,            4'd5,  2'd1, 1'b0, 1'b0},  // R5 same alias twice
        '{2'd2, WE,            4'd5,  2'd2, 1'b0, 1'b0},
        '{2'd1, WF,            4'd6,  2'd0, 1'b0, 1'b0},  // R7 commit slot 5
        '{2'd0, 32'h0000_000F, 4'd15, 2'd0, 1'b1, 1'b0},  // R3
        '{2'd1, WA,            4'd15, 2'd0, 1'b1, 1'b1},  // R4 reject at 15
        '{2'd0, 32'h0000_000B, 4'd11, 2'd0, 1'b0, 1'b0},  // R3 flag clears
        '{2'd3, WG,            4'd11, 2'd1, 1'b0, 1'b0},  // R8 back-to-back
        '{2'd1, WH,            4'd11, 2'd2, 1'b0, 1'b0},
        '{2'd2, WI,            4'd12, 2'd0, 1'b0, 1'b0},  // R7 commit slot 11
        '{2'd1, WB,            4'd12, 2'd0, 1'b0, 1'b1}   // R4 reject at 12
    };

    function automatic logic [95:0] expect_attr(input logic [31:0] a, b, c);
        logic [23:0] x, y, z, w;
        x = c[23:0];
        y = {b[15:0], c[31:24]};
        z = {a[7:0], b[31:16]};
        w = a[31:8];
        return {w, z, y, x};
    endfunction

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [3:0] s, input logic [95:0] exp);
        rd_slot = s;
        #1;
        chk(req, rd_attr, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 slot", 96'(cur_slot), 96'd0);
        chk("R1 count", 96'(word_count), 96'd0);
        chk("R1 errors", 96'({err_immediate, err_range}), 96'd0);
        read_chk("R1 entry0", 4'd0, 96'd0);
        read_chk("R1 entry11", 4'd11, 96'd0);

        // Table walk, one write per cycle with no gaps (R8)
        for (int i = 0; i < NV; i++) begin
            wr_valid = 1'b1;
            wr_addr  = TBL[i].addr;
            wr_data  = TBL[i].data;
            @(negedge clk);
            chk($sformatf("R2/R5/R7 slot v%0d", i), 96'(cur_slot), 96'(TBL[i].slot));
            chk($sformatf("R5 count v%0d", i), 96'(word_count), 96'(TBL[i].cnt));
            chk($sformatf("R3 imm v%0d", i), 96'(err_immediate), 96'(TBL[i].imm));
            chk($sformatf("R4 range v%0d", i), 96'(err_range), 96'(TBL[i].rerr));
        end
        wr_valid = 1'b0;
        @(negedge clk);
        chk("R4 pulse ends", 96'(err_range), 96'd0);

        // R6 unpacking and placement
        read_chk("R6 slot3", 4'd3, expect_attr(WA, WB, WC));
        read_chk("R6 slot3 x field", 4'd3, {72'd0, 24'hAABBCC} | (rd_attr & {72'hFFFFFFFFFFFFFFFFFF, 24'd0}));
        read_chk("R5 slot5 alias order", 4'd5, expect_attr(WD, WE, WF));
        read_chk("R8 slot11", 4'd11, expect_attr(WG, WH, WI));
        read_chk("R4 slot4 untouched", 4'd4, 96'd0);
        read_chk("R4 slot0 untouched", 4'd0, 96'd0);
        read_chk("R9 slot12", 4'd12, 96'd0);
        read_chk("R9 slot15", 4'd15, 96'd0);

        // R8: two attributes streamed back-to-back from slot 0
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 2'd0; wr_data = 32'd0;
        @(negedge clk); wr_addr = 2'd1; wr_data = WC;
        @(negedge clk); wr_data = WB;
        @(negedge clk); wr_data = WA;
        @(negedge clk); wr_addr = 2'd3; wr_data = WI;
        @(negedge clk); wr_data = WH;
        @(negedge clk); wr_data = WG;
        @(negedge clk); wr_valid = 1'b0;
        chk("R7 slot after two", 96'(cur_slot), 96'd2);
        read_chk("R8 slot0", 4'd0, expect_attr(WC, WB, WA));
        read_chk("R8 slot1", 4'd1, expect_attr(WI, WH, WG));

        // R1 reset again clears the store
        do_reset();
        read_chk("R1 entry3 cleared", 4'd3, 96'd0);
        chk("R1 slot cleared", 96'(cur_slot), 96'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule